// File: doc/BRIEF.md
# Byte-Lane Dual-Port Memory Controller

This block is a synchronous model of a shared memory with two fully independent access ports, left and right. Each word is 18 bits wide and splits into two 9-bit lanes: bits 17 to 9 form the upper lane and bits 8 to 0 the lower lane. Each lane can be written or read on its own. Each port has an address, a pair of chip enables of opposite polarity, a read/write strobe, an output enable, one active-low select per lane, and an active-low semaphore select. These controls are decoded every clock into one access mode: idle, write, read or muted.

The memory has no tri-state bus. Each port returns an 18-bit data-out word and one enable flag per lane in place of the bus drivers. Both are registered, so a read sampled on one rising edge shows its data and lane flags after that edge. A lane whose flag is low reads as zero. The depth is 2^ADDR_W words. ADDR_W defaults to 11 to keep the default build small, and the full 32768-word build sets ADDR_W to 15.

Top module: `dpm_top`

## Requirements
- R1: A port is selected only while its first chip enable is low, its second chip enable is high and its semaphore select is high. In every other case the port neither reads nor writes, and both of its lane flags are low after the next edge.
- R2: The upper lane is bits 17..9 and is gated by the active-low upper select. The lower lane is bits 8..0 and is gated by the active-low lower select. A partial write leaves the other lane of the word unchanged.
- R3: On a selected port with the read/write strobe low, each lane whose select is low takes the data input at the edge. The output enable has no effect, and both lane flags are low after that edge.
- R4: On a selected port with the strobe high and the output enable low, each lane whose select is low presents its stored data with its flag high after the sampling edge. A lane whose select is high has its flag low and reads zero.
- R5: With the output enable high and the strobe high, both lane flags are low after the next edge and no data is presented.
- R6: With both lane selects high, a selected port neither writes nor reads, and both lane flags are low after the next edge.
- R7: While the semaphore select is low, a write attempt leaves the memory contents unchanged.
- R8: The two ports work at the same time on different addresses. A word written through one port reads back through the other.
- R9: During reset both ports hold their lane flags low and their data outputs at zero.
- R10: When both ports write the same lanes of one address on the same edge, the right port's data is stored.
- R11: The memory has 2^ADDR_W distinct words. The highest address and address 0 do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the output registers |
| addrL | input | ADDR_W | Left word address |
| ce0nL | input | 1 | Left chip enable, active low |
| ce1L | input | 1 | Left chip enable, active high |
| rwnL | input | 1 | Left strobe: 1 read, 0 write |
| oenL | input | 1 | Left output enable, active low |
| ubnL | input | 1 | Left upper-lane select, active low |
| lbnL | input | 1 | Left lower-lane select, active low |
| semnL | input | 1 | Left semaphore select, active low; low blocks memory access |
| dinL | input | 18 | Left write data |
| doutL | output | 18 | Left registered read data |
| oeUpL | output | 1 | Left upper-lane output flag |
| oeLoL | output | 1 | Left lower-lane output flag |
| addrR | input | ADDR_W | Right word address |
| ce0nR | input | 1 | Right chip enable, active low |
| ce1R | input | 1 | Right chip enable, active high |
| rwnR | input | 1 | Right strobe: 1 read, 0 write |
| oenR | input | 1 | Right output enable, active low |
| ubnR | input | 1 | Right upper-lane select, active low |
| lbnR | input | 1 | Right lower-lane select, active low |
| semnR | input | 1 | Right semaphore select, active low |
| dinR | input | 18 | Right write data |
| doutR | output | 18 | Right registered read data |
| oeUpR | output | 1 | Right upper-lane output flag |
| oeLoR | output | 1 | Right lower-lane output flag |

## Verification
A wrong decode shows up one edge after the faulty sample, as a lane flag in the wrong state. Corrupted array contents are not visible in the same way. A wrong write lane or a write that should have been blocked stays hidden until a later read of that word, so every write stimulus is followed by a read-back. Reads go through both ports and through each lane alone, which exposes swapped lanes and writes that change the other lane.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_WRITE,
    MODE_READ,
    MODE_MUTED
  } mode_e;

  typedef struct packed {
    logic wrUp;
    logic wrLo;
    logic rdUp;
    logic rdLo;
  } laneStrobe_t;
endpackage

// File: rtl/dpm_port_ctrl.sv
module dpm_port_ctrl
  import dpm_pkg::*;
(
  input  logic        ce0n,
  input  logic        ce1,
  input  logic        rwn,
  input  logic        oen,
  input  logic        ubn,
  input  logic        lbn,
  input  logic        semn,
  output laneStrobe_t stb
);
  mode_e mode;
  logic  portSel;
  logic  anyLane;

  always_comb begin
    portSel = !ce0n && ce1 && semn;
    anyLane = !ubn || !lbn;
    if (!portSel || !anyLane) mode = MODE_IDLE;
    else if (!rwn)            mode = MODE_WRITE;
    else if (!oen)            mode = MODE_READ;
    else                      mode = MODE_MUTED;
  end

  always_comb begin
    stb = '0;
    unique case (mode)
      MODE_WRITE: begin
        stb.wrUp = !ubn;
        stb.wrLo = !lbn;
      end
      MODE_READ: begin
        stb.rdUp = !ubn;
        stb.rdLo = !lbn;
      end
      default: stb = '0;
    endcase
  end

  always_comb begin
    assert_no_mixed_rw_R3: assert (!((stb.wrUp || stb.wrLo) && (stb.rdUp || stb.rdLo)));
  end
endmodule

// File: rtl/dpm_datapath.sv
module dpm_datapath
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int DATA_W = 2 * LANE_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PORTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr  [PORTS],
  input  laneStrobe_t       stb   [PORTS],
  input  logic [DATA_W-1:0] din   [PORTS],
  output logic [DATA_W-1:0] dout  [PORTS],
  output logic [1:0]        laneOe[PORTS]
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Port index 1 (right) is written last, so it wins a same-address clash.
  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (stb[p].wrLo) mem[addr[p]][LANE_W-1:0] <= din[p][LANE_W-1:0];
      if (stb[p].wrUp) mem[addr[p]][DATA_W-1:LANE_W] <= din[p][DATA_W-1:LANE_W];
    end
  end

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_rdPort
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dout[gp]   <= '0;
        laneOe[gp] <= '0;
      end else begin
        laneOe[gp] <= {stb[gp].rdUp, stb[gp].rdLo};
        dout[gp][LANE_W-1:0]      <= stb[gp].rdLo ? mem[addr[gp]][LANE_W-1:0] : '0;
        dout[gp][DATA_W-1:LANE_W] <= stb[gp].rdUp ? mem[addr[gp]][DATA_W-1:LANE_W] : '0;
      end
    end

    assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
      (stb[gp].wrUp || stb[gp].wrLo) |=> (laneOe[gp] == 2'b00));

    assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      !stb[gp].rdLo |=> (dout[gp][LANE_W-1:0] == '0));
  end
endmodule

// File: rtl/dpm_top.sv
module dpm_top
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              ce0nL,
  input  logic              ce1L,
  input  logic              rwnL,
  input  logic              oenL,
  input  logic              ubnL,
  input  logic              lbnL,
  input  logic              semnL,
  input  logic [DATA_W-1:0] dinL,
  output logic [DATA_W-1:0] doutL,
  output logic              oeUpL,
  output logic              oeLoL,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              ce0nR,
  input  logic              ce1R,
  input  logic              rwnR,
  input  logic              oenR,
  input  logic              ubnR,
  input  logic              lbnR,
  input  logic              semnR,
  input  logic [DATA_W-1:0] dinR,
  output logic [DATA_W-1:0] doutR,
  output logic              oeUpR,
  output logic              oeLoR
);
  laneStrobe_t       stbArr [2];
  logic [ADDR_W-1:0] addrArr[2];
  logic [DATA_W-1:0] dinArr [2];
  logic [DATA_W-1:0] doutArr[2];
  logic [1:0]        oeArr  [2];

  dpm_port_ctrl u_ctrlL (
    .ce0n(ce0nL), .ce1(ce1L), .rwn(rwnL), .oen(oenL),
    .ubn(ubnL), .lbn(lbnL), .semn(semnL), .stb(stbArr[0])
  );
  dpm_port_ctrl u_ctrlR (
    .ce0n(ce0nR), .ce1(ce1R), .rwn(rwnR), .oen(oenR),
    .ubn(ubnR), .lbn(lbnR), .semn(semnR), .stb(stbArr[1])
  );

  assign addrArr[0] = addrL;
  assign addrArr[1] = addrR;
  assign dinArr[0]  = dinL;
  assign dinArr[1]  = dinR;

  dpm_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .addr(addrArr), .stb(stbArr),
    .din(dinArr), .dout(doutArr), .laneOe(oeArr)
  );

  assign doutL = doutArr[0];
  assign doutR = doutArr[1];
  assign {oeUpL, oeLoL} = oeArr[0];
  assign {oeUpR, oeLoR} = oeArr[1];

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(!ce0nL && ce1L) |=> (!oeUpL && !oeLoL));
  assert_sem_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !semnR |=> (!oeUpR && !oeLoR));
  assert_read_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ce0nL && ce1L && semnL && rwnL && !oenL && !ubnL) |=> oeUpL);
  assert_oe_high_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    oenR |=> (!oeUpR && !oeLoR));
  assert_no_lane_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ubnL && lbnL) |=> (!oeUpL && !oeLoL));
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rstN |=> (doutL == '0 && !oeUpL && !oeLoL && doutR == '0 && !oeUpR && !oeLoR));
endmodule

// File: tb/dpm_top_bench.sv
module dpm_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrL = '0, addrR = '0;
  logic ce0nL = 1, ce1L = 0, rwnL = 1, oenL = 1, ubnL = 1, lbnL = 1, semnL = 1;
  logic ce0nR = 1, ce1R = 0, rwnR = 1, oenR = 1, ubnR = 1, lbnR = 1, semnR = 1;
  logic [17:0] dinL = '0, dinR = '0;
  logic [17:0] doutL, doutR;
  logic oeUpL, oeLoL, oeUpR, oeLoR;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpm_top #(.ADDR_W(AW)) u_dpm_top (
    .clk(clk), .rstN(rstN),
    .addrL(addrL), .ce0nL(ce0nL), .ce1L(ce1L), .rwnL(rwnL), .oenL(oenL),
    .ubnL(ubnL), .lbnL(lbnL), .semnL(semnL), .dinL(dinL),
    .doutL(doutL), .oeUpL(oeUpL), .oeLoL(oeLoL),
    .addrR(addrR), .ce0nR(ce0nR), .ce1R(ce1R), .rwnR(rwnR), .oenR(oenR),
    .ubnR(ubnR), .lbnR(lbnR), .semnR(semnR), .dinR(dinR),
    .doutR(doutR), .oeUpR(oeUpR), .oeLoR(oeLoR)
  );

  typedef struct packed {
    logic          isRead;
    logic          right;
    logic [AW-1:0] addr;
    logic          ubn;
    logic          lbn;
    logic [17:0]   data;
    logic          expUp;
    logic          expLo;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 11'd5,    1'b0, 1'b0, 18'h2A5A5, 1'b0, 1'b0},
    '{1'b1, 1'b1, 11'd5,    1'b0, 1'b0, 18'h2A5A5, 1'b1, 1'b1},
    '{1'b0, 1'b1, 11'd5,    1'b1, 1'b0, 18'h00123, 1'b0, 1'b0},
    '{1'b1, 1'b0, 11'd5,    1'b0, 1'b1, 18'h2A400, 1'b1, 1'b0},
    '{1'b1, 1'b0, 11'd5,    1'b1, 1'b0, 18'h00123, 1'b0, 1'b1},
    '{1'b0, 1'b0, 11'd2047, 1'b0, 1'b0, 18'h3FFFF, 1'b0, 1'b0},
    '{1'b0, 1'b1, 11'd0,    1'b0, 1'b0, 18'h00000, 1'b0, 1'b0},
    '{1'b0, 1'b1, 11'd0,    1'b0, 1'b1, 18'h15555, 1'b0, 1'b0},
    '{1'b1, 1'b0, 11'd0,    1'b0, 1'b0, 18'h15400, 1'b1, 1'b1},
    '{1'b1, 1'b1, 11'd2047, 1'b0, 1'b0, 18'h3FFFF, 1'b1, 1'b1}
  };

  task automatic idleBoth();
    ce0nL = 1; ce1L = 0; rwnL = 1; oenL = 1; ubnL = 1; lbnL = 1; semnL = 1;
    ce0nR = 1; ce1R = 0; rwnR = 1; oenR = 1; ubnR = 1; lbnR = 1; semnR = 1;
  endtask

  task automatic setPort(input bit right, input logic [AW-1:0] a, input bit isRead,
                         input logic ub, input logic lb, input logic [17:0] d);
    if (!right) begin
      addrL = a; ce0nL = 0; ce1L = 1; rwnL = isRead; oenL = !isRead;
      ubnL = ub; lbnL = lb; semnL = 1; dinL = d;
    end else begin
      addrR = a; ce0nR = 0; ce1R = 1; rwnR = isRead; oenR = !isRead;
      ubnR = ub; lbnR = lb; semnR = 1; dinR = d;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkPort(input bit right, input string tag, input logic [17:0] expD,
                           input logic expU, input logic expL);
    logic [17:0] d;
    logic u, l;
    d = right ? doutR : doutL;
    u = right ? oeUpR : oeUpL;
    l = right ? oeLoR : oeLoL;
    checks++;
    if (d !== expD || u !== expU || l !== expL) begin
      errors++;
      $display("FAIL %s port%0s: got data %h up %b lo %b, expected data %h up %b lo %b",
               tag, right ? "R" : "L", d, u, l, expD, expU, expL);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idleBoth();
    @(negedge clk);
    ce0nL = 0; ce1L = 1; rwnL = 1; oenL = 0; ubnL = 0; lbnL = 0;
    step();
    checkPort(0, "R9 reset", 18'h0, 0, 0);
    checkPort(1, "R9 reset", 18'h0, 0, 0);
    rstN = 1;
    idleBoth();
    step();

    // Table walk: R2 R4 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      idleBoth();
      setPort(VECS[i].right, VECS[i].addr, VECS[i].isRead, VECS[i].ubn, VECS[i].lbn,
              VECS[i].data);
      step();
      if (VECS[i].isRead)
        checkPort(VECS[i].right, $sformatf("R2/R4/R11 vector %0d", i),
                  VECS[i].data, VECS[i].expUp, VECS[i].expLo);
      else
        checkPort(VECS[i].right, $sformatf("R3 vector %0d", i), 18'h0, 0, 0);
    end

    // R3: write with output enable low stays quiet
    idleBoth();
    setPort(0, 11'd9, 0, 0, 0, 18'h11111); oenL = 0;
    step();
    checkPort(0, "R3 write oe low", 18'h0, 0, 0);
    idleBoth(); setPort(1, 11'd9, 1, 0, 0, 18'h0);
    step();
    checkPort(1, "R3 readback", 18'h11111, 1, 1);

    // R1: deselected by either chip enable
    idleBoth(); setPort(0, 11'd9, 1, 0, 0, 18'h0); ce0nL = 1;
    step();
    checkPort(0, "R1 ce0n high", 18'h0, 0, 0);
    idleBoth(); setPort(0, 11'd9, 1, 0, 0, 18'h0); ce1L = 0;
    step();
    checkPort(0, "R1 ce1 low", 18'h0, 0, 0);
    idleBoth(); setPort(0, 11'd9, 0, 0, 0, 18'h2FFFF); ce1L = 0;
    step();
    idleBoth(); setPort(0, 11'd9, 1, 0, 0, 18'h0);
    step();
    checkPort(0, "R1 deselected write blocked", 18'h11111, 1, 1);

    // R5: output enable high on a read
    idleBoth(); setPort(1, 11'd9, 1, 0, 0, 18'h0); oenR = 1;
    step();
    checkPort(1, "R5 oe high", 18'h0, 0, 0);

    // R6: both lane selects high
    idleBoth(); setPort(0, 11'd9, 0, 1, 1, 18'h00ABC);
    step();
    idleBoth(); setPort(0, 11'd9, 1, 1, 1, 18'h0);
    step();
    checkPort(0, "R6 no lane read", 18'h0, 0, 0);
    idleBoth(); setPort(0, 11'd9, 1, 0, 0, 18'h0);
    step();
    checkPort(0, "R6 no lane write", 18'h11111, 1, 1);

    // R7: semaphore select low blocks a write
    idleBoth(); setPort(1, 11'd9, 0, 0, 0, 18'h3C3C3); semnR = 0;
    step();
    checkPort(1, "R7 sem quiet", 18'h0, 0, 0);
    idleBoth(); setPort(1, 11'd9, 1, 0, 0, 18'h0);
    step();
    checkPort(1, "R7 sem write blocked", 18'h11111, 1, 1);

    // R8: simultaneous access on different addresses
    idleBoth();
    setPort(0, 11'd20, 0, 0, 0, 18'h0F0F0);
    setPort(1, 11'd21, 0, 0, 0, 18'h30303);
    step();
    idleBoth();
    setPort(0, 11'd21, 1, 0, 0, 18'h0);
    setPort(1, 11'd20, 1, 0, 0, 18'h0);
    step();
    checkPort(0, "R8 cross read", 18'h30303, 1, 1);
    checkPort(1, "R8 cross read", 18'h0F0F0, 1, 1);

    // R10: same address write clash, right wins
    idleBoth();
    setPort(0, 11'd30, 0, 0, 0, 18'h12345);
    setPort(1, 11'd30, 0, 0, 0, 18'h2ABCD);
    step();
    idleBoth(); setPort(0, 11'd30, 1, 0, 0, 18'h0);
    step();
    checkPort(0, "R10 right wins", 18'h2ABCD, 1, 1);

    idleBoth();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule